// File: doc/BRIEF.md
# External Pin Interrupt Controller

A two-channel interrupt source for a small microcontroller. Each channel watches one input pin and raises a request toward the CPU. Four sense modes are available per channel: low level, any change, falling edge and rising edge. The edge modes latch a pending flag, which software clears by writing a one to its bit. The CPU can also clear a flag by pulsing that channel's acknowledge input.

The request line of a channel is gated by its mask enable and by a global interrupt-enable input. The pin is sampled no matter what drives it, so firmware that drives the pin itself can raise an interrupt this way. Three byte-wide registers hold the sense bits, the enables and the flags. Reads have one cycle of latency.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control, mask and flag registers read 0x00 and every request output is low.
- R2: Address 0 is the control register, with bits [2i+1:2i] holding the sense code of channel i. Address 1 is the mask register, with bit i enabling channel i. Address 2 is the flag register, with bit i as the pending flag of channel i. Address 3 reads zero. Control bits 7:4 and mask bits 7:2 ignore writes, and those bits read zero. Flag bits 7:2 also read zero. Read data appears in the cycle after the read strobe.
- R3: Sense code 11 sets the flag on a rising pin edge only. The flag is visible in the third cycle after the pin changes, because of a two-flop synchronizer and one flag register.
- R4: Sense code 10 sets the flag on a falling pin edge only, with the same latency as R3.
- R5: Sense code 01 sets the flag on either pin edge, with the same latency as R3.
- R6: Sense code 00 drives the request directly while the synchronized pin is low, two cycles after the pin falls, and never sets the flag.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R8: In the edge modes a request is high exactly when the flag, the mask enable and the global enable are all one.
- R9: An acknowledge pulse clears the channel's flag at the next clock edge. If a new qualifying edge is seen in the same cycle, the flag stays set.
- R10: Changing the sense code while a channel is enabled can set a spurious flag. An example is going from rising to falling while the pin is low. The sequence disable, change sense, clear flag, re-enable leaves no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | External pins, one per channel |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ack_i | input | 2 | Per-channel acknowledge pulse from the CPU |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, one cycle after re_i |
| irq_o | output | 2 | Per-channel interrupt request |

## Verification
Every edge mode on every channel is swept with both a rising and a falling transition. The request is checked one cycle before and exactly at the expected latency, so a wrong polarity, a missing synchronizer stage or crosstalk between channels each shows as a distinct mismatch. The level mode is driven low and high to separate direct assertion from latching. The mask and global-enable combinations are swept, and one-bit flag write patterns show that clearing is per bit.

Two further tests target ordering. An acknowledge is made to coincide with a new edge to expose priority. A sense change with the pin held steady is made both with and without the safe sequence.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_MASK = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_s_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  input  logic   ack_i,
  output logic   flag_o,
  output logic   level_o
);
  logic cond, cond_q, evt, flag_q;

  // qualified level; a sense change alters it and can fake an edge
  always_comb begin
    case (sense_i)
      SNS_FALL, SNS_LOW: cond = ~pin_s_i;
      default:           cond = pin_s_i;
    endcase
  end

  always_comb begin
    case (sense_i)
      SNS_ANY:            evt = cond ^ cond_q;
      SNS_RISE, SNS_FALL: evt = cond & ~cond_q;
      default:            evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond;
      if (evt)                flag_q <= 1'b1;
      else if (clr_i | ack_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign level_o = (sense_i == SNS_LOW) & ~pin_s_i;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_q);
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !flag_q);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ack_i && !evt) |=> $stable(flag_q));
  p_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !evt) |=> !flag_q);
  p_lvl_noflag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SNS_LOW && !flag_q) |=> !flag_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [NCH-1:0]  flag_i,
  output logic [2*NCH-1:0] ctrl_o,
  output logic [NCH-1:0]  mask_o,
  output logic [NCH-1:0]  clr_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned CW = 2 * NCH;

  logic [CW-1:0]  ctrl_q;
  logic [NCH-1:0] mask_q;
  logic [DW-1:0]  rdata_q, rmux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADR_CTRL) ctrl_q <= wdata_i[CW-1:0];
      if (addr_i == ADR_MASK) mask_q <= wdata_i[NCH-1:0];
    end
  end

  assign clr_o = (we_i && addr_i == ADR_FLAG) ? wdata_i[NCH-1:0] : '0;

  always_comb begin
    rmux = '0;
    case (addr_i)
      ADR_CTRL: rmux[CW-1:0]  = ctrl_q;
      ADR_MASK: rmux[NCH-1:0] = mask_q;
      ADR_FLAG: rmux[NCH-1:0] = flag_i;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rmux;
  end

  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  generate
    if (DW > CW) begin : g_unused
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[DW-1:CW];
    end
  endgenerate

  p_rsvd_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADR_MASK) |=> rdata_o[DW-1:NCH] == '0);
  p_rsvd_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADR_FLAG) |=> rdata_o[DW-1:NCH] == '0);
  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_i,
  input  logic           gie_i,
  input  logic [NCH-1:0] ack_i,
  input  logic [1:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0]   pin_s, flag, level, mask, clr;
  logic [2*NCH-1:0] ctrl;

  ext_irq_sync #(.W(NCH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  ext_irq_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .flag_i(flag), .ctrl_o(ctrl),
    .mask_o(mask), .clr_o(clr), .rdata_o(rdata_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sense_e sense;
    assign sense = sense_e'(ctrl[2*i+1:2*i]);

    ext_irq_chan u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s[i]), .sense_i(sense),
      .clr_i(clr[i]), .ack_i(ack_i[i]), .flag_o(flag[i]), .level_o(level[i])
    );

    assign irq_o[i] = gie_i & mask[i] & ((sense == SNS_LOW) ? level[i] : flag[i]);

    p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (gie_i && mask[i]));
  end
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pin_i = '0;
  logic       gie_i = 1'b0;
  logic [1:0] ack_i = '0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;
  logic [1:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_FLAG = 2'd2, A_NONE = 2'd3;

  always #2 clk_i = ~clk_i;

  ext_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .gie_i(gie_i),
    .ack_i(ack_i), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .re_i(re_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    cyc(1);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; re_i = 1'b1;
    cyc(1);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    @(negedge clk_i);
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1
    rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    rd(A_MASK, r); chk("R1 mask", r, 0);
    rd(A_FLAG, r); chk("R1 flag", r, 0);
    chk("R1 irq", irq_o, 0);

    // R2 reserved bits and empty address
    wr(A_MASK, 8'hFF); rd(A_MASK, r); chk("R2 mask rsvd", r, 8'h03);
    wr(A_CTRL, 8'hFF); rd(A_CTRL, r); chk("R2 ctrl rsvd", r, 8'h0F);
    rd(A_NONE, r); chk("R2 addr3", r, 0);
    rd(A_FLAG, r); chk("R2 flag rsvd", r & 8'hFC, 0);

    // R3 R4 R5 sweep: channel x mode x direction
    gie_i = 1'b1;
    wr(A_MASK, 8'h03);
    for (int ch = 0; ch < 2; ch++) begin
      for (int md = 1; md < 4; md++) begin
        for (int rise = 0; rise < 2; rise++) begin
          string tag;
          logic [1:0] ex;
          tag = (md == 3) ? "R3" : (md == 2) ? "R4" : "R5";
          ex = ((md == 1) || (md == 3 && rise == 1) || (md == 2 && rise == 0))
               ? (2'b01 << ch) : 2'b00;
          pin_i = '0;
          pin_i[ch] = (rise == 0);
          cyc(5);
          wr(A_CTRL, 8'((md << 2) | md));
          cyc(3);
          wr(A_FLAG, 8'hFF);
          cyc(1);
          chk({tag, " idle"}, irq_o, 0);
          pin_i[ch] = ~pin_i[ch];
          cyc(2);
          chk({tag, " early"}, irq_o, 0);
          cyc(1);
          chk({tag, " irq"}, irq_o, ex);
          rd(A_FLAG, r);
          chk({tag, " flag"}, r, 8'(ex));
        end
      end
    end

    // R6 low level on channel 0
    pin_i = 2'b11;
    wr(A_CTRL, 8'h00);
    cyc(5);
    wr(A_FLAG, 8'hFF);
    cyc(1);
    chk("R6 high", irq_o, 0);
    pin_i[0] = 1'b0;
    cyc(1);
    chk("R6 early", irq_o, 0);
    cyc(1);
    chk("R6 low", irq_o, 2'b01);
    rd(A_FLAG, r); chk("R6 noflag", r, 0);
    pin_i[0] = 1'b1;
    cyc(2);
    chk("R6 release", irq_o, 0);

    // R8 gating sweep with flag 0 set
    pin_i = 2'b00;
    wr(A_CTRL, 8'h05);
    cyc(5);
    wr(A_FLAG, 8'hFF);
    pin_i[0] = 1'b1;
    cyc(4);
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 2; g++) begin
        wr(A_MASK, 8'(m));
        gie_i = g[0];
        cyc(1);
        chk("R8 gate", irq_o, 2'((m & g)));
      end
    end

    // R7 write-one-to-clear per bit
    pin_i[1] = 1'b1;
    cyc(4);
    rd(A_FLAG, r); chk("R7 both", r, 8'h03);
    wr(A_FLAG, 8'h01); rd(A_FLAG, r); chk("R7 clr0", r, 8'h02);
    wr(A_FLAG, 8'h00); rd(A_FLAG, r); chk("R7 zero", r, 8'h02);
    wr(A_FLAG, 8'hFE); rd(A_FLAG, r); chk("R7 clr1", r, 8'h00);

    // R9 acknowledge
    wr(A_MASK, 8'h01);
    pin_i[0] = 1'b0;
    cyc(4);
    chk("R9 set", irq_o, 2'b01);
    ack_i[0] = 1'b1;
    cyc(1);
    ack_i[0] = 1'b0;
    chk("R9 ack", irq_o, 0);
    pin_i[0] = 1'b1;
    cyc(4);
    pin_i[0] = 1'b0;
    cyc(2);
    ack_i[0] = 1'b1;
    cyc(1);
    ack_i[0] = 1'b0;
    chk("R9 edge wins", irq_o, 2'b01);

    // R10 sense change hazard and safe sequence
    pin_i = 2'b00;
    wr(A_CTRL, 8'h03);
    cyc(5);
    wr(A_FLAG, 8'hFF);
    cyc(1);
    chk("R10 idle", irq_o, 0);
    wr(A_CTRL, 8'h02);
    cyc(1);
    chk("R10 spurious", irq_o, 2'b01);
    rd(A_FLAG, r); chk("R10 spurious flag", r, 8'h01);
    wr(A_CTRL, 8'h03);
    cyc(3);
    wr(A_FLAG, 8'hFF);
    wr(A_MASK, 8'h00);
    wr(A_CTRL, 8'h02);
    cyc(3);
    wr(A_FLAG, 8'hFF);
    wr(A_MASK, 8'h01);
    cyc(3);
    chk("R10 safe irq", irq_o, 0);
    rd(A_FLAG, r); chk("R10 safe flag", r, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule